// File: doc/BRIEF.md
# Processor Clock Divider and Clock-Output Selector

This block holds a small control register on a system-clock bus. One field of the register reports the divide ratio that produces the processor clock from a fast oscillator. Two more fields choose what appears on a single clock-output pin. The divide ratio arrives from outside on a two-bit input, and the bus can only read it. The divider runs in the oscillator domain. It gives a one-cycle processor-clock enable, plus a square wave that the output selector can route to the pin.

The output selector can drive the pin in four ways. It can hold the pin at a static level that software sets, or it can pass the interface clock, the divided processor clock or the system clock.

Bus accesses use a request/ready handshake with a fixed two-cycle latency:
- The requester raises `bus_req` together with the command. It keeps the request and command steady until it sees `bus_ready`, and it drops the request in that same cycle.
- The block accepts a request only when it is idle. A request held high while an access is in flight is not counted as a second access.
- The block has no back-pressure beyond this fixed latency. Ready always arrives in the second cycle after acceptance.

Top module: `clkctl_top`

## Requirements
- R1: Read data places the divide selection in bits 9:8, the output-source selection in bits 6:5 and the static level in bit 3. Every other bit reads as zero.
- R2: Divide codes 0, 1, 2 and 3 make `mclk_en` pulse for one oscillator cycle every 8, 16, 32 and 64 oscillator cycles.
- R3: The divide field follows `div_sel_in`, which is sampled on the system clock. Bus writes to bits 9:8 have no effect on it.
- R4: Source code 0 drives `clk_out` from the static level (0 gives low, 1 gives high). Code 1 passes `iclk`, code 2 passes the divided processor clock (period equal to the ratio in oscillator cycles), and code 3 passes `sys_clk`.
- R5: After reset the source code is 0, the static level is 0, `clk_out` is low and `bus_ready` is low.
- R6: A write updates the source field and the level bit only when byte strobe `bus_be[0]` is set. Writes to the other lanes and to reserved bits change nothing.
- R7: `bus_ready` is high for exactly one cycle, in the second system-clock cycle after a request is accepted. `bus_rdata` is valid in that cycle and shows the register contents after any write.
- R8: A new divide ratio takes effect only at the next wrap of the counter. Every interval between enables therefore equals either the old ratio or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the bus and the register |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| osc_clk | input | 1 | High-frequency oscillator clock that drives the divider |
| iclk | input | 1 | Interface clock, one of the output sources |
| div_sel_in | input | 2 | Externally supplied divide-ratio code |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle completion flag |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| mclk_en | output | 1 | One-oscillator-cycle processor-clock enable |
| clk_out | output | 1 | Selected clock-output pin value |

## Verification
The bench steps the divide code through the transitions 0→3, 3→1, 1→2 and 2→0. It measures the spacing of the enables across each change. A divider that reloads its ratio in the middle of a count would show a gap that matches neither ratio.

Writes are issued with the source lane disabled, with only the upper lanes set, and with all-ones data. These show whether a design leaks data through the wrong strobe, lets reserved bits read back as nonzero, or lets the bus overwrite the read-only ratio.

Each access checks that ready is low one cycle after the request, high in the second cycle and low again after that. An off-by-one pipeline, or a ready that stays high, fails at once.

Each source code is checked against the live level of its clock. A swapped multiplexer leg shows up as a mismatch.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int REG_W   = 10;
  localparam int DIV_LSB = 8;
  localparam int SRC_LSB = 5;
  localparam int LVL_BIT = 3;
  localparam int MIN_LOG = 3;  // smallest ratio is 2**MIN_LOG

  typedef enum logic [1:0] {
    SRC_LEVEL  = 2'b00,
    SRC_ICLK   = 2'b01,
    SRC_MCLK   = 2'b10,
    SRC_SYSCLK = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'b00,
    ACC_WAIT = 2'b01,
    ACC_DONE = 2'b10
  } acc_state_e;

  function automatic logic [REG_W-1:0] cfg_pack(input logic [1:0] div,
                                                input clk_src_e src,
                                                input logic lvl);
    logic [REG_W-1:0] v;
    v = '0;
    v[DIV_LSB +: 2] = div;
    v[SRC_LSB +: 2] = src;
    v[LVL_BIT]      = lvl;
    return v;
  endfunction

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic [1:0]        div_sel_in,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        div_sel,
  output clk_src_e          src_sel,
  output logic              out_lvl
);

  localparam int SRC_LANE = SRC_LSB / 8;
  localparam int LVL_LANE = LVL_BIT / 8;

  acc_state_e        st_q;
  logic              we_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wd_q;
  logic [1:0]        div_q;
  clk_src_e          src_q;
  logic              lvl_q;
  logic [DATA_W-1:0] rd_q;

  clk_src_e src_nxt;
  logic     lvl_nxt;

  // Next register contents when an access is performed in ACC_WAIT.
  always_comb begin
    src_nxt = src_q;
    lvl_nxt = lvl_q;
    if (we_q && be_q[SRC_LANE]) src_nxt = clk_src_e'(wd_q[SRC_LSB +: 2]);
    if (we_q && be_q[LVL_LANE]) lvl_nxt = wd_q[LVL_BIT];
  end

  // The ratio field is a status copy of the external input.
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) div_q <= 2'b00;
    else        div_q <= div_sel_in;
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ACC_IDLE;
      we_q  <= 1'b0;
      be_q  <= '0;
      wd_q  <= '0;
      src_q <= SRC_LEVEL;
      lvl_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      unique case (st_q)
        ACC_IDLE: begin
          if (bus_req) begin
            we_q <= bus_we;
            be_q <= bus_be;
            wd_q <= bus_wdata;
            st_q <= ACC_WAIT;
          end
        end
        ACC_WAIT: begin
          src_q <= src_nxt;
          lvl_q <= lvl_nxt;
          rd_q  <= DATA_W'(cfg_pack(div_q, src_nxt, lvl_nxt));
          st_q  <= ACC_DONE;
        end
        default: st_q <= ACC_IDLE;
      endcase
    end
  end

  assign bus_ready = (st_q == ACC_DONE);
  assign bus_rdata = rd_q;
  assign div_sel   = div_q;
  assign src_sel   = src_q;
  assign out_lvl   = lvl_q;

endmodule

// File: rtl/clkctl_mdiv.sv
module clkctl_mdiv
  import clkctl_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  output logic       mclk_en,
  output logic       mclk_sq
);

  logic [1:0]       sync_q [SYNC_STAGES];
  logic [1:0]       act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic [CNT_W-1:0] lim;
  logic             wrap;

  // Bring the ratio code into the oscillator domain.
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 2'b00;
    end else begin
      sync_q[0] <= div_sel;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign lim  = CNT_W'((64'd1 << (MIN_LOG + int'(act_q))) - 64'd1);
  assign wrap = (cnt_q == lim);

  // The active ratio is reloaded only at a wrap, so no period is cut short.
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 2'b00;
      en_q  <= 1'b0;
    end else begin
      en_q <= wrap;
      if (wrap) begin
        cnt_q <= '0;
        act_q <= sync_q[SYNC_STAGES-1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mclk_en = en_q;
  assign mclk_sq = cnt_q[MIN_LOG - 1 + int'(act_q)];

endmodule

// File: rtl/clkctl_outmux.sv
module clkctl_outmux
  import clkctl_pkg::*;
(
  input  clk_src_e src_sel,
  input  logic     out_lvl,
  input  logic     iclk,
  input  logic     mclk_sq,
  input  logic     sys_clk,
  output logic     clk_out
);

  always_comb begin
    unique case (src_sel)
      SRC_ICLK:   clk_out = iclk;
      SRC_MCLK:   clk_out = mclk_sq;
      SRC_SYSCLK: clk_out = sys_clk;
      default:    clk_out = out_lvl;
    endcase
  end

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sys_clk,
  input  logic                rst_n,
  input  logic                osc_clk,
  input  logic                iclk,
  input  logic [1:0]          div_sel_in,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                bus_ready,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                mclk_en,
  output logic                clk_out
);

  logic [1:0] div_sel;
  clk_src_e   src_sel;
  logic       out_lvl;
  logic       mclk_sq;

  clkctl_regs #(.DATA_W(DATA_W)) u_regs (
    .sys_clk    (sys_clk),
    .rst_n      (rst_n),
    .div_sel_in (div_sel_in),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .bus_rdata  (bus_rdata),
    .div_sel    (div_sel),
    .src_sel    (src_sel),
    .out_lvl    (out_lvl)
  );

  clkctl_mdiv #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_mdiv (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .mclk_en (mclk_en),
    .mclk_sq (mclk_sq)
  );

  clkctl_outmux u_mux (
    .src_sel (src_sel),
    .out_lvl (out_lvl),
    .iclk    (iclk),
    .mclk_sq (mclk_sq),
    .sys_clk (sys_clk),
    .clk_out (clk_out)
  );

endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk
  import clkctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              sys_clk,
  input logic              osc_clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_ready,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              mclk_en,
  input clk_src_e          src_sel,
  input logic              out_lvl
);

  localparam logic [DATA_W-1:0] LIVE_MASK = DATA_W'(cfg_pack(2'b11, SRC_SYSCLK, 1'b1));

  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (mclk_en) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 8'hFF) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R2 / R8: every enable interval is one of the legal ratios
  a_r2_legal_gap: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (mclk_en && seen_q) |-> (gap_q == 8'd7 || gap_q == 8'd15 || gap_q == 8'd31 || gap_q == 8'd63));

  a_r2_single_pulse: assert property (@(posedge osc_clk) disable iff (!rst_n)
    mclk_en |=> !mclk_en);

  a_r7_ready_latency: assert property (@(posedge sys_clk) disable iff (!rst_n)
    bus_ready |-> $past(bus_req, 2));

  a_r7_ready_one_cycle: assert property (@(posedge sys_clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  a_r1_reserved_zero: assert property (@(posedge sys_clk) disable iff (!rst_n)
    bus_ready |-> ((bus_rdata & ~LIVE_MASK) == '0));

  a_r6_cfg_only_on_access: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !bus_ready |-> ($stable(src_sel) && $stable(out_lvl)));

endmodule

bind clkctl_top clkctl_chk #(.DATA_W(DATA_W)) u_chk (
  .sys_clk   (sys_clk),
  .osc_clk   (osc_clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_ready (bus_ready),
  .bus_rdata (bus_rdata),
  .mclk_en   (mclk_en),
  .src_sel   (src_sel),
  .out_lvl   (out_lvl)
);

// File: tb/clkctl_top_bench.sv
`timescale 1ns/1ps
module clkctl_top_bench;

  localparam real SYS_HALF = 4.0;   // 125 MHz
  localparam real OSC_HALF = 1.0;
  localparam real ICLK_HALF = 7.0;

  logic        sys_clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        iclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  div_sel_in = 2'b00;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        mclk_en;
  logic        clk_out;

  int checks = 0;
  int failures = 0;

  always #(SYS_HALF) sys_clk = ~sys_clk;
  always #(OSC_HALF) osc_clk = ~osc_clk;
  always #(ICLK_HALF) iclk = ~iclk;

  clkctl_top u_clkctl_top (
    .sys_clk    (sys_clk),
    .rst_n      (rst_n),
    .osc_clk    (osc_clk),
    .iclk       (iclk),
    .div_sel_in (div_sel_in),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .bus_rdata  (bus_rdata),
    .mclk_en    (mclk_en),
    .clk_out    (clk_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // One bus access; ready timing (R7) checked on every call.
  task automatic bus_xfer(input logic we, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd);
    @(negedge sys_clk);
    bus_req = 1'b1; bus_we = we; bus_be = be; bus_wdata = wd;
    @(negedge sys_clk);
    check(bus_ready == 1'b0, "R7", "ready one cycle after request", bus_ready, 0);
    @(negedge sys_clk);
    check(bus_ready == 1'b1, "R7", "ready in second cycle", bus_ready, 1);
    rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'h0; bus_wdata = '0;
    @(negedge sys_clk);
    check(bus_ready == 1'b0, "R7", "ready lasts one cycle", bus_ready, 0);
  endtask

  task automatic measure_gap(output int n);
    @(negedge osc_clk);
    while (!mclk_en) @(negedge osc_clk);
    n = 0;
    do begin
      @(negedge osc_clk);
      n++;
    end while (!mclk_en);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    int g;
    check(bus_ready == 1'b0, "R5", "ready after reset", bus_ready, 0);
    check(clk_out == 1'b0, "R5", "clk_out after reset", clk_out, 0);
    bus_xfer(1'b0, 4'h0, '0, rd);
    check(rd == 32'h0, "R5", "register after reset", rd, 0);
    measure_gap(g);
    check(g == 8, "R2", "default ratio gap", g, 8);
  endtask

  task automatic t_lanes();
    logic [31:0] rd;
    bus_xfer(1'b1, 4'b1110, 32'hFFFF_FFFF, rd);
    check(rd == 32'h0, "R6", "write without lane 0", rd, 0);
    bus_xfer(1'b1, 4'b0001, 32'hFFFF_FFFF, rd);
    check(rd == 32'h68, "R1", "all-ones lane-0 write keeps reserved zero", rd, 32'h68);
    bus_xfer(1'b1, 4'b0001, 32'h0000_0020, rd);
    check(rd == 32'h20, "R6", "lane-0 write of source 1", rd, 32'h20);
    bus_xfer(1'b1, 4'b0010, 32'h0000_0300, rd);
    check(rd == 32'h20, "R3", "bus write to ratio field ignored", rd, 32'h20);
    bus_xfer(1'b0, 4'h0, '0, rd);
    check(rd == 32'h20, "R6", "read back after masked writes", rd, 32'h20);
  endtask

  task automatic t_sources();
    logic [31:0] rd;
    realtime t0;
    realtime t1;
    bus_xfer(1'b1, 4'b0001, 32'h08, rd);
    #1;
    check(clk_out == 1'b1, "R4", "static level high", clk_out, 1);
    bus_xfer(1'b1, 4'b0001, 32'h00, rd);
    #1;
    check(clk_out == 1'b0, "R4", "static level low", clk_out, 0);
    bus_xfer(1'b1, 4'b0001, 32'h20, rd);
    @(posedge iclk); #1;
    check(clk_out == 1'b1, "R4", "iclk high leg", clk_out, 1);
    @(negedge iclk); #1;
    check(clk_out == 1'b0, "R4", "iclk low leg", clk_out, 0);
    bus_xfer(1'b1, 4'b0001, 32'h60, rd);
    @(posedge sys_clk); #1;
    check(clk_out == 1'b1, "R4", "sys_clk high leg", clk_out, 1);
    @(negedge sys_clk); #1;
    check(clk_out == 1'b0, "R4", "sys_clk low leg", clk_out, 0);
    bus_xfer(1'b1, 4'b0001, 32'h40, rd);
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); t1 = $realtime;
    check((t1 - t0) == 16.0, "R4", "divided clock period in ps",
          longint'((t1 - t0) * 1000.0), 16000);
  endtask

  task automatic t_ratio(input logic [1:0] code, input int old_n);
    logic [31:0] rd;
    int new_n;
    int g;
    new_n = 8 << code;
    @(negedge sys_clk);
    div_sel_in = code;
    for (int i = 0; i < 3; i++) begin
      measure_gap(g);
      check(g == old_n || g == new_n, "R8", "gap across ratio change", g, new_n);
      if (i == 2) check(g == new_n, "R2", "settled ratio gap", g, new_n);
    end
    bus_xfer(1'b0, 4'h0, '0, rd);
    check(rd[9:8] == code, "R3", "ratio field follows input", rd[9:8], code);
  endtask

  initial begin
    #(SYS_HALF * 2 * 200000.0);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge sys_clk);
    rst_n = 1'b1;
    @(negedge sys_clk);
    t_reset();
    t_lanes();
    t_sources();
    t_ratio(2'd3, 8);
    t_ratio(2'd1, 64);
    t_ratio(2'd2, 16);
    t_ratio(2'd0, 32);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule